// File: doc/BRIEF.md
# Time-Sliced Two-Port Memory

This block gives surrounding logic one write port and one read port on a storage array that has only a single access port. Both ports may be used in the same system cycle. Each system cycle is split into two slots: a read slot, then a write slot. A single address multiplexer steers either the read address or the write address onto the array.

The block runs on a clock at twice the system rate. An internal phase bit starts at zero on reset. The first rising edge after reset is released is a capture edge, and every second rising edge after that is also a capture edge. On a capture edge the request strobes, both addresses and the write data are registered. The read slot lasts until the next rising edge. While it is open, the output latch is transparent to the addressed word. The write slot then runs until the next capture edge, and the write is committed on that edge. Between reads the output latch holds its value.

The word is built from 9-bit lanes, and the lane count is a parameter. The depth is a parameter from 128 to 4096 words.

Top module: `tslot_ram`

## Requirements
- R1: While reset is asserted (rstN low), and after it is released until the first read, rdData is all zeros.
- R2: A write request captured on a capture edge stores wrData at wrAddr. Any read captured on a later capture edge returns that word.
- R3: A read request captured on a capture edge drives rdData with the word at rdAddr. The value is valid before the falling clock edge of the read slot and stays valid until the next read slot opens.
- R4: A read and a write captured on the same capture edge at different addresses both complete within that system cycle.
- R5: When the read and write addresses are equal in the same system cycle, the read returns the contents from before the write. A read in the next system cycle returns the new word.
- R6: In a system cycle with neither request, rdData keeps its last value.
- R7: In a system cycle with only a write request, rdData keeps its last value.
- R8: Requests, addresses and data are sampled only on capture edges. Changes applied across the following non-capture edge cause no write and do not alter rdData.
- R9: Full-array patterns read back exactly: all zeros, all ones, checkerboard (bit b of word a is (a+b) mod 2), marching ones (only bit a mod width set) and marching zeros (the complement of marching ones).
- R10: Address 0 and address DEPTH-1 are both storable and readable without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock; two rising edges per system cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| wrReq | input | 1 | Write request, sampled on capture edges |
| wrAddr | input | ADDR_W | Write word address |
| wrData | input | 9*LANES | Write data |
| rdReq | input | 1 | Read request, sampled on capture edges |
| rdAddr | input | ADDR_W | Read word address |
| rdData | output | 9*LANES | Latched read data |

## Verification
A read and a write can be served in the same system cycle, and this is where the slot ordering matters. The bench provokes this in two ways. It issues both requests together at distinct addresses, and at the same address. It also reads the word written in the previous cycle while writing the next one during every pattern fill. A behavioural reference array judges each read. The reference is updated only after the read has been sampled, so a same-address read must return the old word, and the following cycle must return the new one.

// File: rtl/tslot_pkg.sv
package tslot_pkg;
  localparam int LANE_W = 9;

  typedef struct packed {
    logic readPhase;  // 1 during the read slot, 0 during the write slot
    logic rdPend;     // read captured for the current system cycle
    logic wrPend;     // write captured for the current system cycle
    logic latchOpen;  // output latch transparent
    logic commitWr;   // write lands on the closing edge of the write slot
  } slot_ctrl_t;
endpackage

// File: rtl/tslot_ctrl.sv
module tslot_ctrl
  import tslot_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdReq,
  input  logic       wrReq,
  output slot_ctrl_t strb
);
  logic phaseQ;
  logic rdPendQ;
  logic wrPendQ;

  // phaseQ == 0 means the coming edge is a capture edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ  <= 1'b0;
      rdPendQ <= 1'b0;
      wrPendQ <= 1'b0;
    end else begin
      phaseQ <= ~phaseQ;
      if (!phaseQ) begin
        rdPendQ <= rdReq;
        wrPendQ <= wrReq;
      end
    end
  end

  // one process drives the whole strobe set so it changes atomically
  always_comb begin
    strb.readPhase = phaseQ;
    strb.rdPend    = rdPendQ;
    strb.wrPend    = wrPendQ;
    strb.latchOpen = phaseQ & rdPendQ;
    strb.commitWr  = ~phaseQ & wrPendQ;
  end
endmodule

// File: rtl/tslot_lane.sv
module tslot_lane
  import tslot_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  slot_ctrl_t        strb,
  input  logic [ADDR_W-1:0] wrA,
  input  logic [ADDR_W-1:0] rdA,
  input  logic [LANE_W-1:0] d,
  output logic [LANE_W-1:0] q
);
  logic [LANE_W-1:0] cells [DEPTH];
  logic [ADDR_W-1:0] portAddr;

  // the single array port: read address in the read slot, write address otherwise
  always_comb portAddr = strb.readPhase ? rdA : wrA;

  always_ff @(posedge clk) begin
    if (strb.commitWr) cells[portAddr] <= d;
  end

  always_latch begin
    if (!rstN)               q = '0;
    else if (strb.latchOpen) q = cells[portAddr];
  end

  assert_commit_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.commitWr |=> cells[$past(wrA)] == $past(d));

  assert_read_word_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchOpen |-> q == cells[rdA]);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.readPhase && !strb.rdPend && !strb.wrPend) |-> $stable(q));

  assert_wronly_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.readPhase && strb.wrPend && !strb.rdPend) |-> $stable(q));
endmodule

// File: rtl/tslot_datapath.sv
module tslot_datapath
  import tslot_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int DEPTH  = 512,
  parameter int ADDR_W = $clog2(DEPTH),
  localparam int WORD_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  slot_ctrl_t        strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData
);
  logic [ADDR_W-1:0] wrAddrQ;
  logic [ADDR_W-1:0] rdAddrQ;
  logic [WORD_W-1:0] wrDataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAddrQ <= '0;
      rdAddrQ <= '0;
      wrDataQ <= '0;
    end else if (!strb.readPhase) begin
      wrAddrQ <= wrAddr;
      rdAddrQ <= rdAddr;
      wrDataQ <= wrData;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tslot_lane #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_lane (
      .clk  (clk),
      .rstN (rstN),
      .strb (strb),
      .wrA  (wrAddrQ),
      .rdA  (rdAddrQ),
      .d    (wrDataQ[g*LANE_W +: LANE_W]),
      .q    (rdData[g*LANE_W +: LANE_W])
    );
  end
endmodule

// File: rtl/tslot_ram.sv
module tslot_ram
  import tslot_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int DEPTH  = 512,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int WORD_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrReq,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdReq,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData
);
  slot_ctrl_t strb;

  tslot_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .rdReq (rdReq),
    .wrReq (wrReq),
    .strb  (strb)
  );

  tslot_datapath #(.LANES(LANES), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData)
  );
endmodule

// File: tb/sim_tslot_ram.sv
module sim_tslot_ram;
  localparam int LANES = 2;
  localparam int DEPTH = 512;
  localparam int AW    = $clog2(DEPTH);
  localparam int W     = 9 * LANES;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrReq = 1'b0;
  logic          rdReq = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [W-1:0]  wrData = '0;
  logic [W-1:0]  rdData;

  logic [W-1:0]  model [DEPTH];
  logic [W-1:0]  lastRead = '0;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  tslot_ram #(.LANES(LANES), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one system cycle; starts and ends just after a falling edge before a capture edge
  task automatic sysCycle(input bit w, input logic [AW-1:0] wa, input logic [W-1:0] wd,
                          input bit r, input logic [AW-1:0] ra, output logic [W-1:0] seen);
    wrReq = w; wrAddr = wa; wrData = wd; rdReq = r; rdAddr = ra;
    @(posedge clk);
    @(negedge clk); #1;
    seen = rdData;
    wrReq = 1'b0; rdReq = 1'b0;
    @(posedge clk);
    @(negedge clk); #1;
    if (w) model[wa] = wd;
    if (r) lastRead = seen;
  endtask

  function automatic logic [W-1:0] pat(input int kind, input int a);
    logic [W-1:0] v = '0;
    case (kind)
      0: v = '0;
      1: v = '1;
      2: for (int b = 0; b < W; b++) v[b] = ((a + b) % 2) != 0;
      3: v[a % W] = 1'b1;
      default: begin v[a % W] = 1'b1; v = ~v; end
    endcase
    return v;
  endfunction

  task automatic testReset();
    check("R1 during reset", rdData, '0);
    @(negedge clk); rstN = 1'b1; #1;
    check("R1 after release", rdData, '0);
  endtask

  task automatic testWriteRead();
    logic [W-1:0] s;
    sysCycle(1, 10, 18'h2A5C3, 0, 0, s);
    sysCycle(1, 11, 18'h15A3C, 0, 0, s);
    sysCycle(0, 0, '0, 1, 10, s);
    check("R2 word 10", s, 18'h2A5C3);
    sysCycle(0, 0, '0, 1, 11, s);
    check("R3 word 11", s, 18'h15A3C);
  endtask

  task automatic testConcurrent();
    logic [W-1:0] s;
    sysCycle(1, 20, 18'h3FF00, 1, 10, s);
    check("R4 read side", s, model[10]);
    sysCycle(0, 0, '0, 1, 20, s);
    check("R4 write side", s, 18'h3FF00);
  endtask

  task automatic testSameAddr();
    logic [W-1:0] s;
    logic [W-1:0] old = model[20];
    sysCycle(1, 20, 18'h0C0FE, 1, 20, s);
    check("R5 old word", s, old);
    sysCycle(0, 0, '0, 1, 20, s);
    check("R5 new word", s, 18'h0C0FE);
  endtask

  task automatic testHolds();
    logic [W-1:0] s;
    logic [W-1:0] held = lastRead;
    sysCycle(0, 30, 18'h11111, 0, 11, s);
    check("R6 idle hold", s, held);
    sysCycle(1, 31, 18'h22222, 0, 11, s);
    check("R7 write-only hold", s, held);
    sysCycle(0, 0, '0, 1, 30, s);
    check("R6 idle wrote nothing", s, model[30]);
  endtask

  task automatic testOffEdge();
    logic [W-1:0] exp = model[11];
    wrReq = 1'b0; rdReq = 1'b1; rdAddr = 11; wrAddr = 40; wrData = 18'h12345;
    @(posedge clk);
    @(negedge clk); #1;
    check("R8 captured read", rdData, exp);
    wrReq = 1'b1; rdReq = 1'b1; wrAddr = 41; rdAddr = 10; wrData = 18'h3ABCD;
    @(posedge clk);
    @(negedge clk); #1;
    check("R8 off-edge read ignored", rdData, exp);
    wrReq = 1'b0; rdReq = 1'b0;
    lastRead = exp;
    begin
      logic [W-1:0] s;
      sysCycle(1, 41, 18'h00055, 0, 0, s);
      sysCycle(0, 0, '0, 1, 41, s);
      check("R8 off-edge write ignored", s, 18'h00055);
    end
  endtask

  task automatic testCorners();
    logic [W-1:0] s;
    sysCycle(1, 0, 18'h2AAAA, 0, 0, s);
    sysCycle(1, AW'(DEPTH - 1), 18'h15555, 1, 0, s);
    check("R10 address 0", s, 18'h2AAAA);
    sysCycle(0, 0, '0, 1, AW'(DEPTH - 1), s);
    check("R10 top address", s, 18'h15555);
  endtask

  task automatic testPatterns();
    logic [W-1:0] s;
    for (int k = 0; k < 5; k++) begin
      for (int a = 0; a < DEPTH; a++) begin
        sysCycle(1, AW'(a), pat(k, a), a > 0, AW'(a > 0 ? a - 1 : 0), s);
        if (a > 0) check($sformatf("R9 fill pattern %0d addr %0d", k, a - 1), s, pat(k, a - 1));
      end
      for (int a = 0; a < DEPTH; a++) begin
        sysCycle(0, 0, '0, 1, AW'(a), s);
        check($sformatf("R9 pattern %0d addr %0d", k, a), s, model[a]);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testWriteRead();
    testConcurrent();
    testSameAddr();
    testHolds();
    testOffEdge();
    testCorners();
    testPatterns();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule